// File: doc/BRIEF.md
# Dual-Bank Select and Concurrency Arbiter

This block sits in front of two memory banks, a flash bank and an SRAM bank, that share one address bus, one data bus, one output-enable strobe and one write-enable strobe. Each bank has its own active-low enable. On every clock edge the arbiter samples the shared controls and decides which bank, if any, owns the access. From that decision it issues read and write strobes toward the owning bank, forwards the address and write data, and gates the output enable of the shared data bus. The read data is returned from the owning bank.

The flash enable has priority. If both enables are asserted together, the SRAM enable is ignored and the access goes to flash. With both enables released, the arbiter reports standby and keeps the bus quiet. The arbiter holds no state about flash program or erase activity. The SRAM path therefore stays available while the flash bank runs a long internal operation, which lets code that alters flash execute out of SRAM. Flash writes are blocked unless the flash enable and write enable are low and output enable is high. SRAM accesses beyond the mapped window are dropped.

Top module: `dbsel_arbiter`

## Requirements
- R1: When flash_en_ni and sram_en_ni are both low, the flash bank is selected (flash_sel_o=1, sram_sel_o=0) and the SRAM enable has no effect on any output.
- R2: When both enables are high, standby_o=1, both selects are 0, every read/write strobe is 0 and bus_oe_o=0.
- R3: In every cycle out of reset, exactly one of flash_sel_o, sram_sel_o, standby_o is 1.
- R4: A read of the selected bank occurs when oe_ni=0 and we_ni=1. The bank's read strobe is 1, bus_oe_o=1, and rdata_o carries that bank's read data.
- R5: Whenever oe_ni=1, the next bus_oe_o is 0. Whenever bus_oe_o=0, rdata_o is 0.
- R6: flash_wr_o is 1 only when flash_en_ni=0, we_ni=0 and oe_ni=1. Output enable low, flash enable high or write enable high each inhibit the flash write.
- R7: An SRAM write (sram_wr_o=1) occurs when the SRAM is selected, we_ni=0 and the address is below SRAM_BYTES (default 131072). sram_addr_o carries the low 17 address bits and wdata_o carries the write data. Output enable does not block it.
- R8: SRAM accesses at addresses of SRAM_BYTES or more are ignored. Writes give sram_wr_o=0. Reads give sram_rd_o=0, with bus_oe_o=1 and rdata_o=0.
- R9: All select, strobe, address and data outputs are registered and reflect the inputs sampled at the previous rising edge. In reset, standby_o=1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flash_en_ni | input | 1 | Flash bank enable, active low |
| sram_en_ni | input | 1 | SRAM bank enable, active low |
| oe_ni | input | 1 | Shared output enable, active low |
| we_ni | input | 1 | Shared write enable, active low |
| addr_i | input | ADDR_W (18) | Shared byte address |
| wdata_i | input | DATA_W (8) | Shared write data |
| flash_rdata_i | input | DATA_W | Read data from flash bank |
| sram_rdata_i | input | DATA_W | Read data from SRAM bank |
| flash_sel_o | output | 1 | Flash bank owns the cycle |
| sram_sel_o | output | 1 | SRAM bank owns the cycle |
| standby_o | output | 1 | No bank selected |
| flash_rd_o | output | 1 | Flash read strobe |
| flash_wr_o | output | 1 | Flash write strobe (after inhibit rules) |
| sram_rd_o | output | 1 | SRAM read strobe |
| sram_wr_o | output | 1 | SRAM write strobe |
| flash_addr_o | output | ADDR_W | Address toward flash |
| sram_addr_o | output | SRAM_AW (17) | Address toward SRAM |
| wdata_o | output | DATA_W | Write data toward both banks |
| bus_oe_o | output | 1 | Shared data bus output enable |
| rdata_o | output | DATA_W | Read data returned to the bus |

## Verification
Every select, strobe, address and write-data result is due one rising edge after the controls are applied. The read data follows the same registered selection and returns the bank data in that same cycle. The driver applies each stimulus at a falling edge and queues the expected result. The monitor pops one item per rising edge and compares it shortly after that edge, so each comparison falls in exactly the cycle its result is due. The reset values are checked separately while reset is held.

// File: rtl/dbsel_pkg.sv
package dbsel_pkg;
  typedef struct packed {
    logic flash;
    logic sram;
    logic idle;
  } bank_sel_t;

  typedef struct packed {
    logic flash_rd;
    logic flash_wr;
    logic sram_rd;
    logic sram_wr;
    logic bus_oe;
  } access_t;
endpackage

// File: rtl/dbsel_bank_decode.sv
module dbsel_bank_decode
  import dbsel_pkg::*;
(
  input  logic      flash_en_ni,
  input  logic      sram_en_ni,
  output bank_sel_t sel_o
);
  // flash enable dominates; sram only when flash released
  always_comb begin
    sel_o       = '0;
    sel_o.flash = ~flash_en_ni;
    sel_o.sram  = flash_en_ni & ~sram_en_ni;
    sel_o.idle  = flash_en_ni & sram_en_ni;
  end
endmodule

// File: rtl/dbsel_window.sv
module dbsel_window #(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned SRAM_BYTES = 131072,
  localparam int unsigned SRAM_AW   = $clog2(SRAM_BYTES)
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               in_range_o,
  output logic [SRAM_AW-1:0] sram_addr_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(SRAM_BYTES);

  always_comb begin
    in_range_o  = ({1'b0, addr_i} < LIMIT);
    sram_addr_o = addr_i[SRAM_AW-1:0];
  end
endmodule

// File: rtl/dbsel_access_gate.sv
module dbsel_access_gate
  import dbsel_pkg::*;
(
  input  bank_sel_t sel_i,
  input  logic      oe_ni,
  input  logic      we_ni,
  input  logic      in_range_i,
  output access_t   acc_o
);
  logic rd_cycle;

  always_comb begin
    rd_cycle       = ~oe_ni & we_ni;
    acc_o          = '0;
    acc_o.flash_rd = sel_i.flash & rd_cycle;
    // write inhibit: oe low, enable high or we high blocks flash write
    acc_o.flash_wr = sel_i.flash & ~we_ni & oe_ni;
    acc_o.sram_rd  = sel_i.sram & rd_cycle & in_range_i;
    acc_o.sram_wr  = sel_i.sram & ~we_ni & in_range_i;
    // bus driven for any read cycle of an owned bank, even out of window
    acc_o.bus_oe   = (sel_i.flash | sel_i.sram) & rd_cycle;
  end
endmodule

// File: rtl/dbsel_arbiter.sv
module dbsel_arbiter
  import dbsel_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SRAM_BYTES = 131072,
  localparam int unsigned SRAM_AW   = $clog2(SRAM_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flash_en_ni,
  input  logic               sram_en_ni,
  input  logic               oe_ni,
  input  logic               we_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  flash_rdata_i,
  input  logic [DATA_W-1:0]  sram_rdata_i,
  output logic               flash_sel_o,
  output logic               sram_sel_o,
  output logic               standby_o,
  output logic               flash_rd_o,
  output logic               flash_wr_o,
  output logic               sram_rd_o,
  output logic               sram_wr_o,
  output logic [ADDR_W-1:0]  flash_addr_o,
  output logic [SRAM_AW-1:0] sram_addr_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic               bus_oe_o,
  output logic [DATA_W-1:0]  rdata_o
);
  bank_sel_t          sel_d, sel_q;
  access_t            acc_d, acc_q;
  logic               in_range;
  logic [SRAM_AW-1:0] sram_addr_d;

  dbsel_bank_decode u_decode (
    .flash_en_ni (flash_en_ni),
    .sram_en_ni  (sram_en_ni),
    .sel_o       (sel_d)
  );

  dbsel_window #(
    .ADDR_W     (ADDR_W),
    .SRAM_BYTES (SRAM_BYTES)
  ) u_window (
    .addr_i      (addr_i),
    .in_range_o  (in_range),
    .sram_addr_o (sram_addr_d)
  );

  dbsel_access_gate u_gate (
    .sel_i      (sel_d),
    .oe_ni      (oe_ni),
    .we_ni      (we_ni),
    .in_range_i (in_range),
    .acc_o      (acc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q        <= '{flash: 1'b0, sram: 1'b0, idle: 1'b1};
      acc_q        <= '0;
      flash_addr_o <= '0;
      sram_addr_o  <= '0;
      wdata_o      <= '0;
    end else begin
      sel_q        <= sel_d;
      acc_q        <= acc_d;
      flash_addr_o <= addr_i;
      sram_addr_o  <= sram_addr_d;
      wdata_o      <= wdata_i;
    end
  end

  always_comb begin
    flash_sel_o = sel_q.flash;
    sram_sel_o  = sel_q.sram;
    standby_o   = sel_q.idle;
    flash_rd_o  = acc_q.flash_rd;
    flash_wr_o  = acc_q.flash_wr;
    sram_rd_o   = acc_q.sram_rd;
    sram_wr_o   = acc_q.sram_wr;
    bus_oe_o    = acc_q.bus_oe;
    rdata_o     = '0;
    if (acc_q.flash_rd)     rdata_o = flash_rdata_i;
    else if (acc_q.sram_rd) rdata_o = sram_rdata_i;
  end
endmodule

// File: rtl/dbsel_arbiter_chk.sv
module dbsel_arbiter_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flash_en_ni,
  input logic              sram_en_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              flash_sel_o,
  input logic              sram_sel_o,
  input logic              standby_o,
  input logic              flash_rd_o,
  input logic              flash_wr_o,
  input logic              sram_wr_o,
  input logic              bus_oe_o,
  input logic [DATA_W-1:0] rdata_o
);
  assert_flash_priority_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_en_ni && !sram_en_ni) |=> (flash_sel_o && !sram_sel_o));

  assert_standby_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_en_ni && sram_en_ni) |=> (standby_o && !bus_oe_o && !flash_wr_o && !sram_wr_o));

  assert_one_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({flash_sel_o, sram_sel_o, standby_o}) == 1);

  assert_flash_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_en_ni && !oe_ni && we_ni) |=> (flash_rd_o && bus_oe_o));

  assert_oe_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |=> !bus_oe_o);

  assert_quiet_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> (rdata_o == '0));

  assert_flash_inhibit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni || flash_en_ni || we_ni) |=> !flash_wr_o);

  assert_sram_wr_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_wr_o |-> (sram_sel_o && !flash_sel_o));
endmodule

bind dbsel_arbiter dbsel_arbiter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dbsel_arbiter_tb.sv
module dbsel_arbiter_tb;
  localparam int unsigned AW = 18;
  localparam int unsigned SAW = 17;
  localparam int unsigned SBYTES = 131072;
  localparam logic [7:0] FDATA = 8'hA5;
  localparam logic [7:0] SDATA = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fe_n = 1'b1, se_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wd = '0;
  logic fsel, ssel, stby, frd, fwr, srd, swr, boe;
  logic [AW-1:0] faddr;
  logic [SAW-1:0] saddr;
  logic [7:0] wdo, rdo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected flags: {fsel,ssel,stby,frd,fwr,srd,swr,boe}
  logic [7:0]     q_flags[$];
  logic [7:0]     q_rd[$];
  logic [SAW-1:0] q_saddr[$];
  logic [7:0]     q_wd[$];
  string          q_tag[$];

  always #2.5 clk = ~clk;

  dbsel_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flash_en_ni(fe_n), .sram_en_ni(se_n),
    .oe_ni(oe_n), .we_ni(we_n), .addr_i(addr), .wdata_i(wd),
    .flash_rdata_i(FDATA), .sram_rdata_i(SDATA),
    .flash_sel_o(fsel), .sram_sel_o(ssel), .standby_o(stby),
    .flash_rd_o(frd), .flash_wr_o(fwr), .sram_rd_o(srd), .sram_wr_o(swr),
    .flash_addr_o(faddr), .sram_addr_o(saddr), .wdata_o(wdo),
    .bus_oe_o(boe), .rdata_o(rdo)
  );

  task automatic apply(input logic f, input logic s, input logic o, input logic w,
                       input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    logic e_fs, e_ss, e_sb, inr, e_fr, e_fw, e_sr, e_sw, e_oe;
    logic [7:0] e_rd;
    @(negedge clk);
    fe_n = f; se_n = s; oe_n = o; we_n = w; addr = a; wd = d;
    e_fs = !f;
    e_ss = f && !s;
    e_sb = f && s;
    inr  = (a < SBYTES);
    e_fr = e_fs && !o && w;
    e_fw = e_fs && !w && o;
    e_sr = e_ss && !o && w && inr;
    e_sw = e_ss && !w && inr;
    e_oe = (e_fs || e_ss) && !o && w;
    e_rd = e_fr ? FDATA : (e_sr ? SDATA : 8'h00);
    q_flags.push_back({e_fs, e_ss, e_sb, e_fr, e_fw, e_sr, e_sw, e_oe});
    q_rd.push_back(e_rd);
    q_saddr.push_back(a[SAW-1:0]);
    q_wd.push_back(d);
    q_tag.push_back(tag);
  endtask

  // monitor: one result due per rising edge after a queued stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_flags.size() != 0) begin
        logic [7:0] ef, er, ew;
        logic [SAW-1:0] ea;
        string t;
        ef = q_flags.pop_front(); er = q_rd.pop_front();
        ea = q_saddr.pop_front(); ew = q_wd.pop_front(); t = q_tag.pop_front();
        checks++;
        if ({fsel, ssel, stby, frd, fwr, srd, swr, boe} !== ef || rdo !== er ||
            (ef[1] && (saddr !== ea || wdo !== ew))) begin
          errors++;
          $display("FAIL %s: flags=%b rdata=%h saddr=%h wdata=%h exp flags=%b rdata=%h saddr=%h wdata=%h",
                   t, {fsel, ssel, stby, frd, fwr, srd, swr, boe}, rdo, saddr, wdo, ef, er, ea, ew);
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    checks++;
    if ({fsel, ssel, stby, frd, fwr, srd, swr, boe} !== 8'b0010_0000 || rdo !== 8'h00) begin
      errors++;
      $display("FAIL R9 reset: flags=%b rdata=%h exp flags=00100000 rdata=00",
               {fsel, ssel, stby, frd, fwr, srd, swr, boe}, rdo);
    end
    rst_n = 1'b1;
    apply(1, 1, 1, 1, 18'h00000, 8'h00, "R2 standby");
    apply(0, 1, 0, 1, 18'h21234, 8'h00, "R4 flash read");
    apply(1, 0, 0, 1, 18'h01234, 8'h00, "R4 sram read");
    apply(0, 0, 0, 1, 18'h00010, 8'h00, "R1 both low read goes to flash");
    apply(0, 0, 1, 0, 18'h05555, 8'hAA, "R1 both low write goes to flash");
    apply(1, 1, 0, 1, 18'h00010, 8'h00, "R2 standby with oe low");
    apply(0, 1, 1, 1, 18'h00010, 8'h00, "R5 oe high flash idle bus");
    apply(1, 0, 1, 1, 18'h00010, 8'h00, "R5 oe high sram idle bus");
    apply(0, 1, 1, 0, 18'h02AAA, 8'h55, "R6 flash write allowed");
    apply(0, 1, 0, 0, 18'h02AAA, 8'h55, "R6 flash write inhibited oe low");
    apply(1, 1, 1, 0, 18'h02AAA, 8'h55, "R6 flash write inhibited enable high");
    apply(1, 0, 1, 0, 18'h1FFFF, 8'h7E, "R7 sram write top of window");
    apply(1, 0, 0, 0, 18'h00003, 8'h81, "R7 sram write with oe low");
    apply(1, 0, 1, 0, 18'h20000, 8'h99, "R8 sram write out of window");
    apply(1, 0, 0, 1, 18'h3FFFF, 8'h00, "R8 sram read out of window");
    apply(0, 1, 1, 0, 18'h05555, 8'h80, "R9 back to back flash write");
    apply(1, 0, 0, 1, 18'h00000, 8'h00, "R9 back to back sram read");
    apply(1, 1, 1, 1, 18'h00000, 8'h00, "R3 return to standby");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule